// File: doc/BRIEF.md
# Filtered Edge Capture Unit

This block watches one external input pin on behalf of a 16-bit counter channel. The pin is brought into the clock domain by a two-stage synchronizer and can be inverted. It then passes through a programmable glitch filter that accepts a new level only after seeing it on enough consecutive samples. When the filtered signal makes the edge that the mode field selects, the block copies the running counter value into its capture register. It also sets a sticky edge flag and can tell the counter to reload.

The edge flag leaves the block on one of two request lines, an interrupt or a DMA request, and never on both. Selecting one route turns the other off. The counter itself lives outside the block: it supplies `count_in`, and the block returns a one-cycle `reload` strobe whenever a capture happens while reload-on-capture is enabled.

Top module: `edge_capture_unit`

## Requirements
- R1: While and right after reset, `edge_flag`, `irq`, `dma_req` and `reload` are 0, and `cap_value` is 0.
- R2: With `filt_period` = 0 the filter is bypassed. A pin change that forms a selected edge sets `edge_flag` at the 4th rising clock edge after the change: two synchronizer stages, one filter register, then the capture.
- R3: With `invert` = 1 the pin is inverted before edge detection, so a pin fall counts as a rising edge and a pin rise counts as a falling edge.
- R4: `cap_mode` selects the capturing edge of the polarity-corrected, filtered signal. 2'b00 captures nothing, 2'b01 captures rising edges, 2'b10 captures falling edges, and 2'b11 captures both.
- R5: On a capture, `cap_value` takes the `count_in` value present at the capturing clock edge.
- R6: When `reload_en` = 1, `reload` is high for exactly the one cycle whose closing clock edge performs a capture. It is never high without a capture, and never high while `reload_en` = 0.
- R7: `edge_flag` stays set until `flag_clr` is high at a clock edge. If a capture falls on the same edge as a clear, the flag stays set.
- R8: With `filt_period` = P > 0 and `filt_count` = C, let N = C + 3. The filter samples the input once every P clocks and changes level after N consecutive samples that differ from its current level. A clean pin change therefore sets `edge_flag` between 4 + (N-1)·P and 3 + N·P clock edges after the change.
- R9: With P > 0, a pulse lasting (N-1)·P clocks or less is rejected and never sets `edge_flag`.
- R10: A pulse on `irq_sel` routes the flag to the interrupt and turns the DMA route off. A pulse on `dma_sel` does the reverse. `route_off` turns both off. Priority is `route_off`, then `irq_sel`, then `dma_sel`, so `irq` and `dma_req` are never high together.
- R11: `irq` equals `edge_flag` while the interrupt route is selected, and `dma_req` equals `edge_flag` while the DMA route is selected. Both are 0 otherwise, and the change shows one edge after the select pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_in | input | 1 | Asynchronous external input |
| invert | input | 1 | Invert the input before edge detection |
| cap_mode | input | 2 | Capture edge select: 00 off, 01 rise, 10 fall, 11 both |
| reload_en | input | 1 | Request a counter reload on each capture |
| filt_count | input | FCNT_W | Filter sample count C (N = C + 3 agreeing samples) |
| filt_period | input | FPER_W | Clocks between filter samples; 0 bypasses the filter |
| count_in | input | CNT_W | Running counter value to capture |
| flag_clr | input | 1 | Clear the edge flag |
| irq_sel | input | 1 | Route the flag to the interrupt |
| dma_sel | input | 1 | Route the flag to the DMA request |
| route_off | input | 1 | Disconnect both routes |
| cap_value | output | CNT_W | Captured counter value |
| edge_flag | output | 1 | Sticky input-edge flag |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA request |
| reload | output | 1 | Counter reload strobe |

## Verification
Most internal faults show up as a change in capture latency. A synchronizer or filter register that is stuck, or one stage too long or too short, moves the flag's rise away from edge 4 in bypass mode or outside the N-sample window. The bench measures that rise to the exact edge.

A wrong sample-period phase or run counter lets a glitch of (N-1)·P clocks through, and that shows as a flag within 3 + N·P + 4 cycles. Decode or polarity errors show at once as a flag on the wrong edge. A bad route register shows one edge after a select pulse.

// File: rtl/edge_capture_unit.sv
module edge_capture_unit #(
  parameter int CNT_W  = 16,
  parameter int FCNT_W = 3,
  parameter int FPER_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_in,
  input  logic              invert,
  input  logic [1:0]        cap_mode,
  input  logic              reload_en,
  input  logic [FCNT_W-1:0] filt_count,
  input  logic [FPER_W-1:0] filt_period,
  input  logic [CNT_W-1:0]  count_in,
  input  logic              flag_clr,
  input  logic              irq_sel,
  input  logic              dma_sel,
  input  logic              route_off,
  output logic [CNT_W-1:0]  cap_value,
  output logic              edge_flag,
  output logic              irq,
  output logic              dma_req,
  output logic              reload
);
  localparam int RUN_W = FCNT_W + 2;

  logic              sync1, sync2, filt, prev;
  logic [FPER_W-1:0] div;
  logic [RUN_W-1:0]  run, need;
  logic              pol, tick, bypass, rise, fall, cap_fire;
  logic              irq_en, dma_en;

  assign pol    = sync2 ^ invert;
  assign bypass = (filt_period == '0);
  assign tick   = ({1'b0, div} + 1'b1) >= {1'b0, filt_period};
  assign need   = RUN_W'(filt_count) + RUN_W'(3);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1 <= 1'b0;
      sync2 <= 1'b0;
    end else begin
      sync1 <= pin_in;
      sync2 <= sync1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div  <= '0;
      run  <= '0;
      filt <= 1'b0;
    end else if (bypass) begin
      div  <= '0;
      run  <= '0;
      filt <= pol;
    end else begin
      div <= tick ? '0 : div + 1'b1;
      if (tick) begin
        if (pol == filt) run <= '0;
        else if (run + 1'b1 == need) begin
          filt <= pol;
          run  <= '0;
        end else run <= run + 1'b1;
      end
    end
  end

  assign rise     = filt & ~prev;
  assign fall     = ~filt & prev;
  assign cap_fire = (cap_mode[0] & rise) | (cap_mode[1] & fall);
  assign reload   = cap_fire & reload_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev      <= 1'b0;
      cap_value <= '0;
      edge_flag <= 1'b0;
    end else begin
      prev <= filt;
      if (cap_fire) cap_value <= count_in;
      if (cap_fire) edge_flag <= 1'b1;
      else if (flag_clr) edge_flag <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_en <= 1'b0;
      dma_en <= 1'b0;
    end else if (route_off) begin
      irq_en <= 1'b0;
      dma_en <= 1'b0;
    end else if (irq_sel) begin
      irq_en <= 1'b1;
      dma_en <= 1'b0;
    end else if (dma_sel) begin
      irq_en <= 1'b0;
      dma_en <= 1'b1;
    end
  end

  assign irq     = edge_flag & irq_en;
  assign dma_req = edge_flag & dma_en;

  // R10
  route_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq && dma_req));

  // R7
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    edge_flag && !flag_clr |=> edge_flag);

  // R7
  cap_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_fire |=> edge_flag);

  // R5
  cap_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_fire |=> cap_value == $past(count_in));

  // R4
  mode_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_mode == 2'b00 && !edge_flag && !reload |=> !edge_flag);

  // R6
  reload_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> edge_flag);

endmodule

// File: tb/test_edge_capture_unit.sv
module test_edge_capture_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pin_in = 1'b0, invert = 1'b0, reload_en = 1'b0;
  logic [1:0]  cap_mode = 2'b00;
  logic [2:0]  filt_count = '0;
  logic [7:0]  filt_period = '0;
  logic [15:0] count_in = 16'h1000;
  logic        flag_clr = 1'b0, irq_sel = 1'b0, dma_sel = 1'b0, route_off = 1'b0;
  logic [15:0] cap_value;
  logic        edge_flag, irq, dma_req, reload;
  int          total = 0, fails = 0;
  bit          done = 0;

  edge_capture_unit i_edge_capture_unit (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .invert(invert), .cap_mode(cap_mode),
    .reload_en(reload_en), .filt_count(filt_count), .filt_period(filt_period),
    .count_in(count_in), .flag_clr(flag_clr), .irq_sel(irq_sel), .dma_sel(dma_sel),
    .route_off(route_off), .cap_value(cap_value), .edge_flag(edge_flag), .irq(irq),
    .dma_req(dma_req), .reload(reload));

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic settle();
    repeat (40) @(negedge clk);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
  endtask

  task automatic wait_flag(input int limit, output bit found, output int lat, output int rl);
    found = 0; lat = 0; rl = 0;
    while (lat < limit && !found) begin
      if (reload) rl++;
      @(negedge clk);
      lat++;
      if (edge_flag) found = 1;
      else count_in = count_in + 16'd1;
    end
  endtask

  initial begin
    bit found;
    int lat, rl;
    logic lvl;
    repeat (3) @(negedge clk);
    chk(edge_flag == 0 && irq == 0 && dma_req == 0 && reload == 0 && cap_value == 0,
        "R1", "outputs in reset", {edge_flag, irq, dma_req, reload}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(edge_flag == 0 && cap_value == 0, "R1", "after reset", int'(cap_value), 0);

    // R2 R3 R4 R5: bypass-mode sweep over polarity, mode and pin direction
    for (int inv = 0; inv < 2; inv++)
      for (int m = 0; m < 4; m++)
        for (int d = 0; d < 2; d++) begin
          bit eff_rise, trig;
          invert = inv[0]; cap_mode = 2'b00; pin_in = ~d[0];
          settle();
          cap_mode = m[1:0];
          pin_in = d[0];
          eff_rise = d[0] ^ inv[0];
          trig = eff_rise ? m[0] : m[1];
          wait_flag(12, found, lat, rl);
          if (trig) begin
            chk(found && lat == 4, inv ? "R3" : "R2", "capture latency", lat, 4);
            chk(cap_value == count_in, "R5", "captured value", int'(cap_value), int'(count_in));
          end else
            chk(!found, "R4", "unselected edge ignored", int'(found), 0);
          chk(rl == 0, "R6", "no reload when disabled", rl, 0);
        end

    // R6 reload strobe
    invert = 0; cap_mode = 2'b00; pin_in = 0; settle();
    reload_en = 1; cap_mode = 2'b01; pin_in = 1;
    wait_flag(12, found, lat, rl);
    chk(found && rl == 1, "R6", "reload cycles on capture", rl, 1);
    cap_mode = 2'b00; pin_in = 0;
    wait_flag(12, found, lat, rl);
    chk(rl == 0, "R6", "reload without capture", rl, 0);
    reload_en = 0;

    // R7 sticky flag and clear/capture collision
    repeat (20) @(negedge clk);
    chk(edge_flag == 1, "R7", "flag sticky", int'(edge_flag), 1);
    cap_mode = 2'b11; pin_in = 1;
    repeat (3) @(negedge clk);
    flag_clr = 1;
    @(negedge clk);
    flag_clr = 0;
    chk(edge_flag == 1, "R7", "capture beats clear", int'(edge_flag), 1);
    chk(cap_value == count_in, "R5", "value on collision", int'(cap_value), int'(count_in));
    flag_clr = 1;
    @(negedge clk);
    flag_clr = 0;
    chk(edge_flag == 0, "R7", "clear", int'(edge_flag), 0);

    // R10 R11 routing
    pin_in = 0;
    wait_flag(12, found, lat, rl);
    @(negedge clk);
    chk(irq == 0 && dma_req == 0, "R11", "no route", {irq, dma_req}, 0);
    irq_sel = 1; @(negedge clk); irq_sel = 0;
    chk(irq == 1 && dma_req == 0, "R10", "irq route", {irq, dma_req}, 2);
    dma_sel = 1; @(negedge clk); dma_sel = 0;
    chk(irq == 0 && dma_req == 1, "R10", "dma route", {irq, dma_req}, 1);
    irq_sel = 1; dma_sel = 1; @(negedge clk); irq_sel = 0; dma_sel = 0;
    chk(irq == 1 && dma_req == 0, "R10", "irq priority", {irq, dma_req}, 2);
    route_off = 1; irq_sel = 1; @(negedge clk); route_off = 0; irq_sel = 0;
    chk(irq == 0 && dma_req == 0, "R10", "route off", {irq, dma_req}, 0);
    dma_sel = 1; @(negedge clk); dma_sel = 0;
    flag_clr = 1; @(negedge clk); flag_clr = 0;
    chk(dma_req == 0 && irq == 0, "R11", "request follows flag", {irq, dma_req}, 0);

    // R8 R9 filter sweep
    cap_mode = 2'b11;
    lvl = 0;
    for (int p = 1; p < 4; p++)
      for (int c = 0; c < 4; c++) begin
        int n, lo, hi;
        n = c + 3; lo = 4 + (n - 1) * p; hi = 3 + n * p;
        filt_period = 8'(p); filt_count = 3'(c);
        settle();
        lvl = ~lvl; pin_in = lvl;
        wait_flag(hi + 2, found, lat, rl);
        chk(found && lat >= lo && lat <= hi, "R8", "filtered latency", lat, hi);
        settle();
        pin_in = ~lvl;
        repeat ((n - 1) * p) @(negedge clk);
        pin_in = lvl;
        repeat (hi + 4) @(negedge clk);
        chk(edge_flag == 0, "R9", "glitch rejected", int'(edge_flag), 0);
      end

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: got %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule